// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Receive DMA

This block moves an incoming byte stream into memory. The bytes are placed in buffers that a chain of four-word descriptors defines. Each descriptor holds, at word offsets 0 to 3: a link to the next descriptor, the buffer start address, a flag word, and the buffer end address. The end address is exclusive. The transmit engine shares this layout, so offsets and flag bits are fixed: bit 0 marks the last descriptor of the list, bit 4 requests an interrupt on completion, and bit 11 is written by this block when a packet ended inside the buffer.

Software places the descriptor chain in memory and pulses `start` with the address of the first descriptor and the address of a context descriptor. The engine then reads a descriptor and accepts one byte per handshake until the buffer is full or the source marks end of packet. It then writes back the flag word and the real fill point, and follows the link. After the last descriptor it sets the disable bit in the context descriptor's flag word (word 1, bit 15) and refuses further data. Four raw interrupt bits record what happened. They stay set until they are cleared.

Top module: `stream_rx_dma`

## Requirements
- R1: After reset `in_ready`, `mem_en`, `irq_raw` and `at_eol` are all 0.
- R2: A start reads the four descriptor words at the descriptor address plus 0, 4, 8 and 12, in that order, one per cycle. Memory read data is expected one cycle after the request. `in_ready` is low while descriptors are fetched or written back.
- R3: Each accepted byte is written to memory as a single-byte write at the current buffer pointer, and the pointer then advances by one. With no valid data the engine waits in place with `in_ready` high.
- R4: A descriptor whose start equals its end is closed without accepting any byte.
- R5: A descriptor closes when the pointer reaches the end address or when the accepted byte carries `in_eop`. A packet that ends exactly at the buffer end closes the descriptor once, and the next byte goes to the next descriptor.
- R6: On close, the flag word is written back to offset 8 and then the current pointer to offset 12. An early packet end therefore shrinks the end field to the fill point.
- R7: On close of a descriptor with flag bit 4 set, raw interrupt bits 0 and 1 are both set. Raw bits never clear except through `irq_clr`.
- R8: On close caused by end of packet, flag bit 11 is set in the written-back flag word and raw interrupt bit 3 is set.
- R9: After write-back of a descriptor without flag bit 0, the descriptor at its link address is fetched. The buffer pointer restarts at that descriptor's start field.
- R10: After write-back of a descriptor with flag bit 0, the context flag word at context address plus 4 is read, then written back with bit 15 set. `at_eol` then rises, and no further byte is accepted (`in_ready` stays low).
- R11: Each set bit of `irq_clr` clears the matching raw bit on the next edge, unless the same edge sets it. A start while `at_eol` is high clears `at_eol` and begins a new chain.
- R12: A start pulse while the engine is fetching, receiving or writing back is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain (honoured when idle or at end of list) |
| start_desc | input | AW | Address of the first data descriptor |
| start_ctx | input | AW | Address of the context descriptor |
| in_valid | input | 1 | Source byte is valid |
| in_data | input | 8 | Source byte |
| in_eop | input | 1 | This byte ends the packet |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = single byte in `mem_wdata[7:0]`, 0 = full word |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| irq_clr | input | 4 | Clear mask for raw interrupt bits |
| irq_raw | output | 4 | Raw interrupt bits (0,1 completion; 3 packet end; 2 unused) |
| at_eol | output | 1 | Chain finished and context disabled |

## Verification
The assertions assume well-formed descriptors. Each start address lies at or below its end address, so counting up from start always meets end. They also assume that memory returns read data exactly one cycle after a read request, and that no descriptor in a chain is visited twice. The bench builds only such chains in a single-cycle memory model. Its reference model works out the full ordered list of memory accesses from the initial memory image and the byte stream. Every request the engine issues is compared against that list as it happens.

// File: rtl/stream_rx_dma.sv
module stream_rx_dma #(
  parameter int AW       = 32,
  parameter int WORD     = 32,
  parameter int BW       = 8,
  parameter int IRQW     = 4,
  parameter int EOL_BIT  = 0,
  parameter int INTR_BIT = 4,
  parameter int IEOP_BIT = 11,
  parameter int DIS_BIT  = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_desc,
  input  logic [AW-1:0]   start_ctx,
  input  logic            in_valid,
  input  logic [BW-1:0]   in_data,
  input  logic            in_eop,
  output logic            in_ready,
  output logic            mem_en,
  output logic            mem_we,
  output logic            mem_byte,
  output logic [AW-1:0]   mem_addr,
  output logic [WORD-1:0] mem_wdata,
  input  logic [WORD-1:0] mem_rdata,
  input  logic [IRQW-1:0] irq_clr,
  output logic [IRQW-1:0] irq_raw,
  output logic            at_eol
);
  localparam int WB = WORD / 8;
  localparam logic [AW-1:0] OFS_FLG  = AW'(2 * WB);
  localparam logic [AW-1:0] OFS_END  = AW'(3 * WB);
  localparam logic [AW-1:0] OFS_CFLG = AW'(WB);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RUN, S_WBF, S_WBE, S_CRD, S_CWR, S_HALT} st_t;
  st_t st;

  logic [2:0]      idx;
  logic [AW-1:0]   dsc, ctx, nxt, ptr, endp;
  logic [WORD-1:0] flg;

  wire            beat       = (st == S_RUN) && in_valid;
  wire [AW-1:0]   ptr_inc    = ptr + 1'b1;
  wire            last_fetch = (st == S_FETCH) && (idx == 3'd4);
  wire            empty_dsc  = last_fetch && (mem_rdata[AW-1:0] == ptr);
  wire            close_eop  = beat && in_eop;
  wire            close      = empty_dsc || (beat && (ptr_inc == endp || in_eop));
  wire [IRQW-1:0] raw_set    = close ? IRQW'({close_eop, 1'b0, {2{flg[INTR_BIT]}}}) : '0;

  assign in_ready = (st == S_RUN);
  assign at_eol   = (st == S_HALT);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_FETCH: begin
        mem_en   = (idx < 3'd4);
        mem_addr = dsc + AW'(32'(idx) * WB);
      end
      S_RUN: begin
        mem_en    = in_valid;
        mem_we    = 1'b1;
        mem_byte  = 1'b1;
        mem_addr  = ptr;
        mem_wdata = WORD'(in_data);
      end
      S_WBF: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dsc + OFS_FLG;
        mem_wdata = flg;
      end
      S_WBE: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dsc + OFS_END;
        mem_wdata = WORD'(ptr);
      end
      S_CRD: begin
        mem_en   = 1'b1;
        mem_addr = ctx + OFS_CFLG;
      end
      S_CWR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ctx + OFS_CFLG;
        mem_wdata = mem_rdata | (WORD'(1) << DIS_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      dsc     <= '0;
      ctx     <= '0;
      nxt     <= '0;
      ptr     <= '0;
      endp    <= '0;
      flg     <= '0;
      irq_raw <= '0;
    end else begin
      irq_raw <= (irq_raw & ~irq_clr) | raw_set;
      case (st)
        S_IDLE, S_HALT:
          if (start) begin
            dsc <= start_desc;
            ctx <= start_ctx;
            idx <= '0;
            st  <= S_FETCH;
          end
        S_FETCH: begin
          idx <= idx + 3'd1;
          case (idx)
            3'd1: nxt  <= mem_rdata[AW-1:0];
            3'd2: ptr  <= mem_rdata[AW-1:0];
            3'd3: flg  <= mem_rdata;
            3'd4: endp <= mem_rdata[AW-1:0];
            default: ;
          endcase
          if (last_fetch) st <= empty_dsc ? S_WBF : S_RUN;
        end
        S_RUN:
          if (beat) begin
            ptr <= ptr_inc;
            if (ptr_inc == endp || in_eop) st <= S_WBF;
            if (in_eop) flg[IEOP_BIT] <= 1'b1;
          end
        S_WBF: st <= S_WBE;
        S_WBE:
          if (flg[EOL_BIT]) st <= S_CRD;
          else begin
            dsc <= nxt;
            idx <= '0;
            st  <= S_FETCH;
          end
        S_CRD: st <= S_CWR;
        S_CWR: st <= S_HALT;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ptr_short_of_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (ptr != endp));

  assert_eol_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    at_eol |-> (!in_ready && !mem_en));

  assert_raw_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr == '0) |=> ((irq_raw & $past(irq_raw)) == $past(irq_raw)));

  assert_eop_sets_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop && !irq_clr[3]) |=> irq_raw[3]);

  assert_eop_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop) |=> (mem_en && mem_we && !mem_byte && !in_ready));

  assert_fetch_reads_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_FETCH) && mem_en) |-> (!mem_we && !in_ready));

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st == S_RUN) && !in_valid) |=> (st == S_RUN));
endmodule

// File: tb/stream_rx_dma_test.sv
module stream_rx_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_desc = '0, start_ctx = '0;
  logic        in_valid = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, mem_en, mem_we, mem_byte, at_eol;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  irq_clr = '0, irq_raw;

  always #4 clk = ~clk;

  stream_rx_dma uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc), .start_ctx(start_ctx),
    .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop), .in_ready(in_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_clr(irq_clr), .irq_raw(irq_raw),
    .at_eol(at_eol)
  );

  logic [7:0] mem [int unsigned];

  function automatic logic [7:0] bat(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rdw(int unsigned a);
    return {bat(a + 3), bat(a + 2), bat(a + 1), bat(a)};
  endfunction
  function automatic void wrw(int unsigned a, logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endfunction

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) begin
        if (mem_byte) mem[mem_addr] = mem_wdata[7:0];
        else wrw(mem_addr, mem_wdata);
      end else mem_rdata <= rdw(mem_addr);
    end

  typedef struct {bit we; bit bt; int unsigned a; logic [31:0] d; string tag;} acc_t;
  typedef struct {logic [7:0] d; bit e;} sb_t;
  acc_t expq[$];
  sb_t  sq[$];
  int tests = 0, fails = 0, exp_left = 0;
  logic [3:0] exp_raw = '0;
  bit exp_halt = 0;

  function automatic void chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] ex);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, ex);
    end
  endfunction

  function automatic void push(bit we, bit bt, int unsigned a, logic [31:0] d, string tag);
    acc_t x;
    x.we = we; x.bt = bt; x.a = a; x.d = d; x.tag = tag;
    expq.push_back(x);
  endfunction

  function automatic void model(int unsigned d, int unsigned c);
    int k = 0;
    int unsigned nx, p, e;
    logic [31:0] f;
    bit eop;
    exp_halt = 0;
    forever begin
      for (int i = 0; i < 4; i++) push(0, 0, d + 4 * i, '0, "R2");
      nx = rdw(d); p = rdw(d + 4); f = rdw(d + 8); e = rdw(d + 12);
      eop = 0;
      if (p != e) begin
        forever begin
          if (k >= sq.size()) begin
            exp_left = 0;
            return;
          end
          push(1, 1, p, {24'h0, sq[k].d}, "R3");
          p++;
          eop = sq[k].e;
          k++;
          if (p == e || eop) break;
        end
      end
      if (f[4]) exp_raw |= 4'b0011;
      if (eop) begin
        f[11] = 1'b1;
        exp_raw |= 4'b1000;
      end
      push(1, 0, d + 8, f, "R6");
      push(1, 0, d + 12, p, "R6");
      if (f[0]) begin
        push(0, 0, c + 4, '0, "R10");
        push(1, 0, c + 4, rdw(c + 4) | 32'h8000, "R10");
        exp_halt = 1;
        exp_left = sq.size() - k;
        return;
      end
      d = nx;
    end
  endfunction

  task automatic tick();
    acc_t x;
    @(negedge clk);
    if (sq.size() > 0) begin
      in_valid = 1'b1; in_data = sq[0].d; in_eop = sq[0].e;
    end else begin
      in_valid = 1'b0; in_eop = 1'b0;
    end
    #1;
    if (mem_en) begin
      if (expq.size() == 0) chk(0, "R12", "unexpected access", mem_addr, 32'h0);
      else begin
        x = expq.pop_front();
        chk(mem_we == x.we && mem_byte == x.bt && mem_addr == x.a && (!x.we || mem_wdata == x.d),
            x.tag, x.we ? "write data" : "read address",
            x.we ? mem_wdata : mem_addr, x.we ? x.d : x.a);
      end
    end
    if (in_valid && in_ready) void'(sq.pop_front());
  endtask

  task automatic add_pkt(int n, int base);
    sb_t b;
    for (int i = 0; i < n; i++) begin
      b.d = 8'(base + i); b.e = (i == n - 1);
      sq.push_back(b);
    end
  endtask

  task automatic run(int unsigned d, int unsigned c, int poke);
    model(d, c);
    start_desc = d; start_ctx = c; start = 1'b1;
    tick();
    start = 1'b0;
    chk(at_eol == 1'b0, "R11", "at_eol after start", 32'(at_eol), 32'h0);
    for (int i = 0; i < 400; i++) begin
      if (i == poke) begin
        start = 1'b1; start_desc = 32'h100;
      end
      tick();
      start = 1'b0;
      if (expq.size() == 0 && i > 20) break;
    end
    repeat (5) tick();
    chk(expq.size() == 0, "R9", "accesses still pending", 32'(expq.size()), 32'h0);
    chk(irq_raw == exp_raw, "R7", "raw interrupt bits", 32'(irq_raw), 32'(exp_raw));
    chk(at_eol == exp_halt, "R10", "end-of-list state", 32'(at_eol), 32'(exp_halt));
    chk(sq.size() == exp_left, "R5", "bytes left unaccepted", 32'(sq.size()), 32'(exp_left));
    if (exp_halt) chk(in_ready == 1'b0, "R10", "ready after end of list", 32'(in_ready), 32'h0);
  endtask

  task automatic clear_irq();
    irq_clr = 4'hF;
    tick();
    irq_clr = 4'h0;
    exp_raw = '0;
    chk(irq_raw == 4'h0, "R11", "raw bits after clear", 32'(irq_raw), 32'h0);
  endtask

  initial begin
    repeat (3) tick();
    chk(!in_ready && !mem_en && irq_raw == 0 && !at_eol, "R1", "reset outputs",
        {in_ready, mem_en, at_eol, irq_raw}, 32'h0);
    rst_n = 1'b1;
    tick();

    // single eol descriptor, early packet end shrinks end, extra bytes refused (R8, R10)
    wrw(32'h100, 32'h0); wrw(32'h104, 32'h1000); wrw(32'h108, 32'h11); wrw(32'h10C, 32'h1008);
    wrw(32'h84, 32'h3);
    add_pkt(5, 8'h10);
    add_pkt(2, 8'h40);
    run(32'h100, 32'h80, -1);
    chk(rdw(32'h10C) == 32'h1005, "R6", "shrunk end field", rdw(32'h10C), 32'h1005);
    chk(rdw(32'h108) == 32'h811, "R8", "in-descriptor eop flag", rdw(32'h108), 32'h811);
    chk(rdw(32'h84) == 32'h8003, "R10", "context disable bit", rdw(32'h84), 32'h8003);
    sq.delete();
    clear_irq();

    // chain: exact-fit packet end (R5), full buffer with intr (R7), zero-length (R4), restart (R11), ignored start (R12)
    wrw(32'h200, 32'h210); wrw(32'h204, 32'h2000); wrw(32'h208, 32'h00); wrw(32'h20C, 32'h2004);
    wrw(32'h210, 32'h220); wrw(32'h214, 32'h2100); wrw(32'h218, 32'h10); wrw(32'h21C, 32'h2104);
    wrw(32'h220, 32'h230); wrw(32'h224, 32'h2200); wrw(32'h228, 32'h00); wrw(32'h22C, 32'h2200);
    wrw(32'h230, 32'h0);   wrw(32'h234, 32'h2300); wrw(32'h238, 32'h01); wrw(32'h23C, 32'h2310);
    wrw(32'h94, 32'h0);
    add_pkt(4, 8'h50);
    add_pkt(6, 8'h60);
    run(32'h200, 32'h90, 3);
    chk(rdw(32'h20C) == 32'h2004, "R5", "exact-fit end field", rdw(32'h20C), 32'h2004);
    chk(rdw(32'h22C) == 32'h2200, "R4", "zero-length end field", rdw(32'h22C), 32'h2200);
    chk(rdw(32'h23C) == 32'h2302, "R6", "last end field", rdw(32'h23C), 32'h2302);
    chk(bat(32'h2301) == 8'h65, "R3", "byte in last buffer", 32'(bat(32'h2301)), 32'h65);
    clear_irq();

    // stalled source mid-buffer: engine waits ready (R3)
    wrw(32'h300, 32'h310); wrw(32'h304, 32'h3000); wrw(32'h308, 32'h10); wrw(32'h30C, 32'h3008);
    add_pkt(3, 8'h70);
    sq[2].e = 1'b0;
    run(32'h300, 32'hA0, -1);
    chk(in_ready == 1'b1, "R3", "waiting for data", 32'(in_ready), 32'h1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule